// File: doc/BRIEF.md
# Tagged Set-Associative Corrector Predictor

This block is a small, tagged, set-associative table that sits behind a primary branch direction predictor and overrules it only for the histories it has learned to get right. A lookup presents a set index, a tag and the primary predictor's direction. One cycle later the block reports whether a confident entry matched, whether that entry contradicts the primary, and the final direction to use. Index and tag formation, the primary predictor and any fetch redirection sit outside the block.

Each entry holds a valid flag, a tag, a saturating confidence counter and a saturating direction counter. When the branch resolves, an update presents the same set and tag, the real outcome, the primary's direction and whether the corrector supplied a prediction at lookup time. A matching entry trains its direction counter toward the outcome. Its confidence rises only when it was right where the primary was wrong, and falls otherwise. A primary misprediction that the corrector did not cover and that matches no entry claims a way in the set. An empty way is taken first; otherwise the way with the lowest confidence is taken.

The table is one synchronous memory word per set, so it maps onto block RAM. Updates are read-modify-write over two cycles, with a forwarding path for back-to-back updates to one set. After reset a sweep clears every set before the block accepts traffic.

Top module: `rare_corrector`

## Requirements
- R1: After reset the block clears one set per cycle for SETS cycles. During that sweep res_valid stays 0 even if lk_valid is high, and updates are dropped. Afterwards every entry is empty.
- R2: res_valid is high in the cycle after a cycle with lk_valid high. res_hit is 1 only if a valid entry in the set carries the tag and its confidence is at least MIN_CONF (2). A matching entry with lower confidence gives res_hit 0.
- R3: res_override is 1 exactly when res_hit is 1 and the entry's direction differs from lk_primary. The entry's direction is the direction counter's most significant bit, with 1 meaning taken. res_taken is the entry's direction on an override and lk_primary otherwise.
- R4: An update allocates when upd_outcome differs from upd_primary, upd_provided is 0 and no valid entry in the set carries upd_tag. The new entry holds upd_tag, confidence 0 and direction counter 2 (weakly taken) if the outcome is taken, or 1 (weakly not taken) if not.
- R5: An update that matches no entry allocates nothing if upd_primary equals upd_outcome or if upd_provided is 1.
- R6: On a matching update, confidence increments if the entry's direction equals upd_outcome and upd_primary does not. In every other case it decrements. It saturates at 0 and at 2^CONF_W-1.
- R7: On every matching update, the direction counter steps one toward upd_outcome, saturating at 0 and 2^CTR_W-1.
- R8: The allocation victim is the lowest-numbered empty way if any way is empty. Otherwise it is the way with the lowest confidence, with the lowest-numbered way winning a tie.
- R9: A lookup issued in the same cycle as an update to the same set sees the contents before that update. A lookup two cycles later sees the result. Updates to one set in consecutive cycles take effect in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_set | input | $clog2(SETS) | Lookup set index |
| lk_tag | input | TAG_W | Lookup tag |
| lk_primary | input | 1 | Primary predictor direction (1 = taken) |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Confident tag match |
| res_override | output | 1 | Corrector contradicts the primary |
| res_taken | output | 1 | Final direction |
| upd_valid | input | 1 | Update request |
| upd_set | input | $clog2(SETS) | Update set index |
| upd_tag | input | TAG_W | Update tag |
| upd_outcome | input | 1 | Resolved direction |
| upd_primary | input | 1 | Primary direction given for this branch |
| upd_provided | input | 1 | Corrector supplied a prediction at lookup |

## Verification
The bench builds the block with 4 sets, 4 ways, 6-bit tags, a 3-bit confidence counter and a 2-bit direction counter. With these values a set fills after four allocations, so eviction ties and the preference for empty ways can be reached directly. The confidence counter reaches its ceiling of 7 within a handful of corrective updates, which exposes any wrap at the top. A behavioural table in the bench predicts each lookup result. The bench also drives same-cycle and back-to-back updates to one set, which exercises the forwarding path.

// File: rtl/rare_corrector_pkg.sv
package rare_corrector_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_TRAIN = 2'd1,
    ACT_ALLOC = 2'd2
  } upd_act_e;
endpackage

// File: rtl/cp_set_match.sv
// Tag compare across the ways of one set; reports the lowest matching way.
module cp_set_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 10,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]       vld_vec,
  input  logic [WAYS*TAG_W-1:0] tag_vec,
  input  logic [TAG_W-1:0]      tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way
);
  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = vld_vec[g] && (tag_vec[g*TAG_W +: TAG_W] == tag);
  end

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit     = 1'b1;
        hit_way = w[WAY_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cp_victim.sv
// Victim choice: first empty way, else lowest confidence (lowest index on tie).
module cp_victim #(
  parameter int WAYS   = 8,
  parameter int CONF_W = 6,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]        vld_vec,
  input  logic [WAYS*CONF_W-1:0] conf_vec,
  output logic [WAY_W-1:0]       victim_way
);
  logic              any_free;
  logic [WAY_W-1:0]  free_way;
  logic [WAY_W-1:0]  min_way;
  logic [CONF_W-1:0] min_conf;

  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_vec[w]) begin
        any_free = 1'b1;
        free_way = w[WAY_W-1:0];
      end
    end
  end

  always_comb begin
    min_way  = '0;
    min_conf = conf_vec[0 +: CONF_W];
    for (int w = 1; w < WAYS; w++) begin
      if (conf_vec[w*CONF_W +: CONF_W] < min_conf) begin
        min_conf = conf_vec[w*CONF_W +: CONF_W];
        min_way  = w[WAY_W-1:0];
      end
    end
  end

  assign victim_way = any_free ? free_way : min_way;
endmodule

// File: rtl/cp_train.sv
// Next-state of one entry for a training or allocating update.
module cp_train
  import rare_corrector_pkg::*;
#(
  parameter int TAG_W  = 10,
  parameter int CONF_W = 6,
  parameter int CTR_W  = 2,
  localparam int ENT_W = 1 + TAG_W + CONF_W + CTR_W
) (
  input  logic [ENT_W-1:0] old_entry,
  input  logic [TAG_W-1:0] tag,
  input  upd_act_e         act,
  input  logic             outcome,
  input  logic             primary,
  output logic [ENT_W-1:0] new_entry
);
  localparam logic [CONF_W-1:0] CONF_MAX = '1;
  localparam logic [CTR_W-1:0]  CTR_MAX  = '1;
  localparam logic [CTR_W-1:0]  WEAK_T   = CTR_W'(1) << (CTR_W - 1);
  localparam logic [CTR_W-1:0]  WEAK_N   = WEAK_T - CTR_W'(1);

  logic [CTR_W-1:0]  ctr_o, ctr_n;
  logic [CONF_W-1:0] conf_o, conf_n;
  logic [TAG_W-1:0]  tag_n;
  logic              vld_n;
  logic              pred;

  assign ctr_o  = old_entry[0 +: CTR_W];
  assign conf_o = old_entry[CTR_W +: CONF_W];
  assign pred   = ctr_o[CTR_W-1];

  always_comb begin
    vld_n  = old_entry[ENT_W-1];
    tag_n  = old_entry[CTR_W+CONF_W +: TAG_W];
    conf_n = conf_o;
    ctr_n  = ctr_o;
    case (act)
      ACT_ALLOC: begin
        vld_n  = 1'b1;
        tag_n  = tag;
        conf_n = '0;
        ctr_n  = outcome ? WEAK_T : WEAK_N;
      end
      ACT_TRAIN: begin
        if ((pred == outcome) && (primary != outcome)) begin
          if (conf_o != CONF_MAX) conf_n = conf_o + CONF_W'(1);
        end else begin
          if (conf_o != '0) conf_n = conf_o - CONF_W'(1);
        end
        if (outcome) begin
          if (ctr_o != CTR_MAX) ctr_n = ctr_o + CTR_W'(1);
        end else begin
          if (ctr_o != '0) ctr_n = ctr_o - CTR_W'(1);
        end
      end
      default: ;
    endcase
  end

  assign new_entry = {vld_n, tag_n, conf_n, ctr_n};
endmodule

// File: rtl/rare_corrector.sv
module rare_corrector
  import rare_corrector_pkg::*;
#(
  parameter int SETS     = 512,
  parameter int WAYS     = 8,
  parameter int TAG_W    = 10,
  parameter int CONF_W   = 6,
  parameter int CTR_W    = 2,
  parameter int MIN_CONF = 2,
  localparam int SET_W   = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             lk_primary,
  output logic             res_valid,
  output logic             res_hit,
  output logic             res_override,
  output logic             res_taken,
  input  logic             upd_valid,
  input  logic [SET_W-1:0] upd_set,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic             upd_outcome,
  input  logic             upd_primary,
  input  logic             upd_provided
);
  localparam int ENT_W  = 1 + TAG_W + CONF_W + CTR_W;
  localparam int WORD_W = WAYS * ENT_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_LO = CTR_W + CONF_W;
  localparam logic [SET_W:0]    LAST_SET = (SET_W + 1)'(SETS - 1);
  localparam logic [CONF_W-1:0] CONF_MIN = CONF_W'(MIN_CONF);

  // ---------------- storage: one word per set ----------------
  logic [WORD_W-1:0] mem [SETS];
  logic              wr_en;
  logic [SET_W-1:0]  wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic [WORD_W-1:0] lk_word;
  logic [WORD_W-1:0] up_word;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    lk_word <= mem[lk_set];
    up_word <= mem[upd_set];
  end

  // ---------------- clearing sweep ----------------
  logic           init_busy;
  logic [SET_W:0] init_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_busy <= 1'b1;
      init_cnt  <= '0;
    end else if (init_busy) begin
      init_cnt <= init_cnt + 1'b1;
      if (init_cnt == LAST_SET) init_busy <= 1'b0;
    end
  end

  // ---------------- lookup path ----------------
  logic             lk_q_valid;
  logic [TAG_W-1:0] lk_q_tag;
  logic             lk_q_prim;

  always_ff @(posedge clk) begin
    if (rst) lk_q_valid <= 1'b0;
    else     lk_q_valid <= lk_valid && !init_busy;
    lk_q_tag  <= lk_tag;
    lk_q_prim <= lk_primary;
  end

  logic [WAYS-1:0]       lk_vld;
  logic [WAYS*TAG_W-1:0] lk_tags;
  logic                  lk_hit;
  logic [WAY_W-1:0]      lk_way;

  for (genvar g = 0; g < WAYS; g++) begin : g_lk_fields
    assign lk_vld[g]                  = lk_word[g*ENT_W + ENT_W - 1];
    assign lk_tags[g*TAG_W +: TAG_W]  = lk_word[g*ENT_W + TAG_LO +: TAG_W];
  end

  cp_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) lk_match_i (
    .vld_vec (lk_vld),
    .tag_vec (lk_tags),
    .tag     (lk_q_tag),
    .hit     (lk_hit),
    .hit_way (lk_way)
  );

  logic [CONF_W-1:0] lk_conf;
  logic              lk_dir;
  logic              lk_qual;

  assign lk_conf = lk_word[32'(lk_way)*ENT_W + CTR_W +: CONF_W];
  assign lk_dir  = lk_word[32'(lk_way)*ENT_W + CTR_W - 1];
  assign lk_qual = lk_hit && (lk_conf >= CONF_MIN);

  assign res_valid    = lk_q_valid;
  assign res_hit      = lk_q_valid && lk_qual;
  assign res_override = res_hit && (lk_dir != lk_q_prim);
  assign res_taken    = res_override ? lk_dir : lk_q_prim;

  // ---------------- update path (read, then modify and write) ----------------
  logic             ua_valid;
  logic [SET_W-1:0] ua_set;
  logic [TAG_W-1:0] ua_tag;
  logic             ua_out, ua_prim, ua_prov;
  logic             byp_hit;
  logic [WORD_W-1:0] byp_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      ua_valid <= 1'b0;
      byp_hit  <= 1'b0;
    end else begin
      ua_valid <= upd_valid && !init_busy;
      byp_hit  <= wr_en && (wr_addr == upd_set);
    end
    ua_set   <= upd_set;
    ua_tag   <= upd_tag;
    ua_out   <= upd_outcome;
    ua_prim  <= upd_primary;
    ua_prov  <= upd_provided;
    byp_word <= wr_data;
  end

  logic [WORD_W-1:0]      ua_word;
  logic [WAYS-1:0]        ua_vld;
  logic [WAYS*TAG_W-1:0]  ua_tags;
  logic [WAYS*CONF_W-1:0] ua_confs;

  assign ua_word = byp_hit ? byp_word : up_word;

  for (genvar g = 0; g < WAYS; g++) begin : g_ua_fields
    assign ua_vld[g]                    = ua_word[g*ENT_W + ENT_W - 1];
    assign ua_tags[g*TAG_W +: TAG_W]    = ua_word[g*ENT_W + TAG_LO +: TAG_W];
    assign ua_confs[g*CONF_W +: CONF_W] = ua_word[g*ENT_W + CTR_W +: CONF_W];
  end

  logic             ua_hit;
  logic [WAY_W-1:0] ua_hit_way;
  logic [WAY_W-1:0] vic_way;

  cp_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) ua_match_i (
    .vld_vec (ua_vld),
    .tag_vec (ua_tags),
    .tag     (ua_tag),
    .hit     (ua_hit),
    .hit_way (ua_hit_way)
  );

  cp_victim #(.WAYS(WAYS), .CONF_W(CONF_W)) victim_i (
    .vld_vec    (ua_vld),
    .conf_vec   (ua_confs),
    .victim_way (vic_way)
  );

  upd_act_e         act;
  logic [WAY_W-1:0] tgt_way;
  logic [ENT_W-1:0] old_entry, new_entry;
  logic [WORD_W-1:0] merged;

  always_comb begin
    if (!ua_valid)                             act = ACT_NONE;
    else if (ua_hit)                           act = ACT_TRAIN;
    else if ((ua_out != ua_prim) && !ua_prov)  act = ACT_ALLOC;
    else                                       act = ACT_NONE;
  end

  assign tgt_way   = ua_hit ? ua_hit_way : vic_way;
  assign old_entry = ua_word[32'(tgt_way)*ENT_W +: ENT_W];

  cp_train #(.TAG_W(TAG_W), .CONF_W(CONF_W), .CTR_W(CTR_W)) train_i (
    .old_entry (old_entry),
    .tag       (ua_tag),
    .act       (act),
    .outcome   (ua_out),
    .primary   (ua_prim),
    .new_entry (new_entry)
  );

  always_comb begin
    merged = ua_word;
    merged[32'(tgt_way)*ENT_W +: ENT_W] = new_entry;
  end

  // write port: sweep first, then trained or allocated sets
  always_comb begin
    wr_en   = !rst && (init_busy || (act != ACT_NONE));
    wr_addr = init_busy ? init_cnt[SET_W-1:0] : ua_set;
    wr_data = init_busy ? '0 : merged;
  end
endmodule

// File: rtl/rare_corrector_chk.sv
module rare_corrector_chk (
  input logic clk,
  input logic rst,
  input logic init_busy,
  input logic lk_valid,
  input logic lk_primary,
  input logic res_valid,
  input logic res_hit,
  input logic res_override,
  input logic res_taken
);
  assert_no_result_in_sweep_R1: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !$past(init_busy));

  assert_result_follows_lookup_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(lk_valid));

  assert_hit_needs_result_R2: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_valid);

  assert_override_needs_hit_R3: assert property (@(posedge clk) disable iff (rst)
    res_override |-> res_hit);

  assert_override_flips_R3: assert property (@(posedge clk) disable iff (rst)
    res_override |-> (res_taken != $past(lk_primary)));

  assert_keep_primary_R3: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_override) |-> (res_taken == $past(lk_primary)));
endmodule

bind rare_corrector rare_corrector_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .init_busy    (init_busy),
  .lk_valid     (lk_valid),
  .lk_primary   (lk_primary),
  .res_valid    (res_valid),
  .res_hit      (res_hit),
  .res_override (res_override),
  .res_taken    (res_taken)
);

// File: tb/rare_corrector_tb_top.sv
module rare_corrector_tb_top;
  localparam int S  = 4;
  localparam int W  = 4;
  localparam int TW = 6;
  localparam int CW = 3;
  localparam int KW = 2;
  localparam int SW = $clog2(S);
  localparam int CONF_MAX = (1 << CW) - 1;
  localparam int CTR_MAX  = (1 << KW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0, lk_primary = 1'b0;
  logic [SW-1:0] lk_set = '0;
  logic [TW-1:0] lk_tag = '0;
  logic res_valid, res_hit, res_override, res_taken;
  logic upd_valid = 1'b0, upd_outcome = 1'b0, upd_primary = 1'b0, upd_provided = 1'b0;
  logic [SW-1:0] upd_set = '0;
  logic [TW-1:0] upd_tag = '0;

  always #5 clk = ~clk;

  rare_corrector #(.SETS(S), .WAYS(W), .TAG_W(TW), .CONF_W(CW), .CTR_W(KW), .MIN_CONF(2)) dut_i (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_set(lk_set), .lk_tag(lk_tag), .lk_primary(lk_primary),
    .res_valid(res_valid), .res_hit(res_hit), .res_override(res_override), .res_taken(res_taken),
    .upd_valid(upd_valid), .upd_set(upd_set), .upd_tag(upd_tag), .upd_outcome(upd_outcome),
    .upd_primary(upd_primary), .upd_provided(upd_provided)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // behavioural table built from the requirements
  bit m_v    [S][W];
  int m_tag  [S][W];
  int m_conf [S][W];
  int m_ctr  [S][W];

  logic [2:0] exp_q[$];
  string      req_q[$];

  task automatic check(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int find_way(input int s, input int t);
    for (int w = 0; w < W; w++) if (m_v[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int pick_victim(input int s);
    int best;
    for (int w = 0; w < W; w++) if (!m_v[s][w]) return w;
    best = 0;
    for (int w = 1; w < W; w++) if (m_conf[s][w] < m_conf[s][best]) best = w;
    return best;
  endfunction

  task automatic model_update(input int s, input int t, input bit o, input bit p, input bit pv);
    int w;
    bit pred;
    w = find_way(s, t);
    if (w >= 0) begin
      pred = (m_ctr[s][w] >= (1 << (KW - 1)));
      if (pred == o && p != o) begin
        if (m_conf[s][w] < CONF_MAX) m_conf[s][w]++;
      end else if (m_conf[s][w] > 0) m_conf[s][w]--;
      if (o) begin
        if (m_ctr[s][w] < CTR_MAX) m_ctr[s][w]++;
      end else if (m_ctr[s][w] > 0) m_ctr[s][w]--;
    end else if (o != p && !pv) begin
      w = pick_victim(s);
      m_v[s][w] = 1'b1; m_tag[s][w] = t; m_conf[s][w] = 0;
      m_ctr[s][w] = o ? (1 << (KW - 1)) : (1 << (KW - 1)) - 1;
    end
  endtask

  function automatic logic [2:0] model_lookup(input int s, input int t, input bit p);
    int w;
    bit dir, hit, ovr;
    w = find_way(s, t);
    hit = (w >= 0) && (m_conf[s][w] >= 2);
    dir = (w >= 0) && (m_ctr[s][w] >= (1 << (KW - 1)));
    ovr = hit && (dir != p);
    return {hit, ovr, ovr ? dir : p};
  endfunction

  // driver tasks: each lookup pushes its expected result into the queue
  task automatic lookup(input int s, input int t, input bit p, input string req);
    lk_valid = 1'b1; lk_set = SW'(s); lk_tag = TW'(t); lk_primary = p;
    exp_q.push_back(model_lookup(s, t, p));
    req_q.push_back(req);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic update(input int s, input int t, input bit o, input bit p, input bit pv,
                        input bit settle);
    upd_valid = 1'b1; upd_set = SW'(s); upd_tag = TW'(t);
    upd_outcome = o; upd_primary = p; upd_provided = pv;
    model_update(s, t, o, p, pv);
    @(negedge clk);
    if (settle) begin
      upd_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic lookup_with_update(input int s, input int t, input bit p,
                                    input bit o, input bit up, input string req);
    lk_valid = 1'b1; lk_set = SW'(s); lk_tag = TW'(t); lk_primary = p;
    exp_q.push_back(model_lookup(s, t, p));
    req_q.push_back(req);
    upd_valid = 1'b1; upd_set = SW'(s); upd_tag = TW'(t);
    upd_outcome = o; upd_primary = up; upd_provided = 1'b1;
    model_update(s, t, o, up, 1'b1);
    @(negedge clk);
    lk_valid = 1'b0; upd_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pops and compares each result as it appears
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        check("R2", 1, 0, "unexpected result");
      end else begin
        logic [2:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, int'(res_hit),      int'(e[2]), "res_hit");
        check(r, int'(res_override), int'(e[1]), "res_override");
        check(r, int'(res_taken),    int'(e[0]), "res_taken");
      end
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog", 1, 0, "run did not finish");
    summary();
  end

  initial begin
    for (int s = 0; s < S; s++)
      for (int w = 0; w < W; w++) begin
        m_v[s][w] = 1'b0; m_tag[s][w] = 0; m_conf[s][w] = 0; m_ctr[s][w] = 0;
      end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: lookups and updates presented during the sweep are dropped
    lk_valid = 1'b1; lk_set = '0; lk_tag = TW'(5); lk_primary = 1'b1;
    upd_valid = 1'b1; upd_set = '0; upd_tag = TW'(5);
    upd_outcome = 1'b0; upd_primary = 1'b1; upd_provided = 1'b0;
    for (int i = 0; i < S; i++) begin
      @(negedge clk);
      check("R1", int'(res_valid), 0, "res_valid in sweep");
    end
    lk_valid = 1'b0; upd_valid = 1'b0;
    @(negedge clk);
    check("R1", int'(res_valid), 0, "res_valid after sweep");
    @(negedge clk);
    // R1: if the sweep update had allocated, two trainings would make it hit
    update(0, 5, 0, 1, 1, 1);
    update(0, 5, 0, 1, 1, 1);
    lookup(0, 5, 1, "R1");

    // R2/R3: miss keeps primary
    lookup(1, 3, 1, "R2");
    // R4: allocate, weak counter, confidence 0 gives no hit
    update(1, 3, 0, 1, 0, 1);
    lookup(1, 3, 1, "R4");
    // R6: two corrective updates reach the threshold
    update(1, 3, 0, 1, 1, 1);
    update(1, 3, 0, 1, 1, 1);
    lookup(1, 3, 1, "R3");
    lookup(1, 3, 0, "R3");
    // R6: agreement with primary decrements
    update(1, 3, 0, 0, 1, 1);
    lookup(1, 3, 1, "R6");
    // R6: saturation at the top, then count down
    repeat (10) update(1, 3, 0, 1, 1, 1);
    repeat (6)  update(1, 3, 0, 0, 1, 1);
    lookup(1, 3, 1, "R6");
    update(1, 3, 0, 1, 1, 1);
    lookup(1, 3, 1, "R6");
    // R7: direction counter walks toward the outcome and saturates
    repeat (5) update(1, 3, 0, 1, 1, 1);
    update(1, 3, 1, 1, 1, 1);
    lookup(1, 3, 1, "R7");
    update(1, 3, 1, 1, 1, 1);
    lookup(1, 3, 0, "R7");
    repeat (3) update(1, 3, 1, 0, 1, 1);
    update(1, 3, 0, 0, 1, 1);
    lookup(1, 3, 0, "R7");

    // R8: fill set 2, raise confidences, then evict
    for (int t = 10; t < 14; t++) update(2, t, 1, 0, 0, 1);
    repeat (3) update(2, 10, 1, 0, 1, 1);
    update(2, 11, 1, 0, 1, 1);
    update(2, 12, 1, 0, 1, 1);
    repeat (2) update(2, 13, 1, 0, 1, 1);
    update(2, 14, 1, 0, 0, 1);
    repeat (2) update(2, 11, 1, 0, 1, 1);
    lookup(2, 11, 0, "R8");
    update(2, 12, 1, 0, 1, 1);
    lookup(2, 12, 0, "R8");
    repeat (2) update(2, 14, 1, 0, 1, 1);
    lookup(2, 14, 0, "R8");
    lookup(2, 10, 0, "R8");

    // R5: no allocation when primary was right or corrector had provided
    update(3, 20, 1, 0, 1, 1);
    repeat (2) update(3, 20, 1, 0, 1, 1);
    lookup(3, 20, 0, "R5");
    update(3, 21, 1, 1, 0, 1);
    repeat (2) update(3, 21, 1, 0, 1, 1);
    lookup(3, 21, 0, "R5");

    // R9: same-cycle lookup sees old contents; later lookup sees new
    update(3, 30, 1, 0, 0, 1);
    repeat (2) update(3, 30, 1, 0, 1, 1);
    lookup_with_update(3, 30, 0, 1, 1, "R9");
    lookup(3, 30, 0, "R9");
    // R9: back-to-back updates to one set take effect in order
    update(3, 30, 1, 0, 1, 0);
    update(3, 30, 1, 0, 1, 1);
    lookup(3, 30, 0, "R9");
    update(3, 31, 0, 1, 0, 0);
    update(3, 31, 0, 1, 1, 0);
    update(3, 31, 0, 1, 1, 1);
    lookup(3, 31, 1, "R9");

    repeat (4) @(negedge clk);
    check("R2", exp_q.size(), 0, "results outstanding");
    summary();
  end
endmodule